// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block produces the control-memory address for every cycle of a microprogrammed control unit. It keeps a 7-bit control address register, which is the `car` output, and a one-level return register for subroutines. In each cycle it reads the current 20-bit microinstruction, three status bits and the 4-bit opcode of the machine instruction. From these it loads the next address from one of four sources:

- the current address plus one;
- the 7-bit address field of the microinstruction;
- a routine address derived from the opcode;
- the saved return address.

A 2-bit condition selector picks the status bit to test. A 2-bit branch type picks the kind of transfer. The word layout, from the most significant bit down, is: three 3-bit operation fields (bits 19..11), the condition selector (bits 10..9), the branch type (bits 8..7) and the address field (bits 6..0). The sequencer ignores the operation fields, which drive the datapath. The `car` output addresses an external control memory with a one-cycle read. The word that memory returns for `car` is the microinstruction presented in that cycle.

Top module: `useq_sequencer`

## Requirements
- R1: A synchronous reset, active high, loads the control address with 64 (binary 1000000, the start of instruction fetch). The address reads 64 on the first cycle after reset.
- R2: The condition selector gives a true condition as follows: code 00 always true, 01 the indirect bit, 10 the accumulator sign bit, 11 the accumulator-zero flag.
- R3: With branch type 00 (jump) or 01 (call), a true condition loads the address field into the control address.
- R4: With branch type 00 or 01, a false condition loads the current address plus one, modulo 128, so 127 is followed by 0.
- R5: A taken call (branch type 01 with a true condition) stores the current address plus one, modulo 128, in the return register.
- R6: Branch type 10 (return) loads the return register into the control address, whatever the condition selector and status bits are.
- R7: Branch type 11 (map) loads the address formed as a 0 bit, then the 4 opcode bits, then 00, which is opcode times 4. It does this whatever the condition selector and status bits are.
- R8: The return register changes only on a taken call. A call that is not taken, a jump, a return or a map leaves it unchanged.
- R9: The three operation fields (bits 19..11) have no effect on the control address or on the return register.
- R10: Reset also sets the return register to 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| uword | input | 20 | Current microinstruction: operation fields, condition selector, branch type, address field |
| ind_bit | input | 1 | Indirect bit of the current machine instruction |
| ac_sign | input | 1 | Accumulator sign (negative) bit |
| ac_zero | input | 1 | Accumulator-zero flag |
| opcode | input | 4 | Opcode of the current machine instruction |
| car | output | 7 | Current control address |

## Verification
Two functions can act in the same cycle. A taken call writes the return register while it also redirects the address, and a return in the very next cycle reads the value written one edge earlier. The bench provokes this with a taken call whose target holds a return. It repeats the case with the call placed at address 127, so the saved value wraps to 0. A bench model that keeps its own address and return values judges every cycle. That model is also checked over a long stretch of random words with mixed branch types, status bits and occasional resets.

// File: rtl/useq_pkg.sv
package useq_pkg;

    parameter int AW      = 7;   // control address width
    parameter int OPW     = 4;   // machine opcode width
    parameter int FW      = 3;   // width of one operation field
    parameter int NFIELDS = 3;   // number of operation fields
    parameter int CW      = 2;   // condition selector width
    parameter int BW      = 2;   // branch type width

    localparam int UW       = NFIELDS * FW + CW + BW + AW;
    localparam int MAP_LSB  = 2;                      // trailing zeros in mapped address
    localparam int NSTAT    = 3;
    localparam logic [AW-1:0] FETCH_ADDR = AW'(1) << (AW - 1);
    localparam logic [AW-1:0] ADDR_ONE   = AW'(1);

    typedef enum logic [CW-1:0] {
        COND_ALWAYS = 2'b00,
        COND_IND    = 2'b01,
        COND_SIGN   = 2'b10,
        COND_ZERO   = 2'b11
    } cond_e;

    typedef enum logic [BW-1:0] {
        BR_JUMP   = 2'b00,
        BR_CALL   = 2'b01,
        BR_RETURN = 2'b10,
        BR_MAP    = 2'b11
    } br_e;

    typedef enum logic [1:0] {
        SRC_INC,
        SRC_FIELD,
        SRC_MAP,
        SRC_SAVED
    } src_e;

    typedef struct packed {
        logic [NFIELDS*FW-1:0] ops;
        cond_e                 cd;
        br_e                   br;
        logic [AW-1:0]         ad;
    } uword_t;

    typedef struct packed {
        logic indirect;
        logic sign;
        logic zero;
    } status_t;

    function automatic logic [AW-1:0] map_opcode(input logic [OPW-1:0] op);
        return AW'(op) << MAP_LSB;
    endfunction

    function automatic logic [AW-1:0] addr_inc(input logic [AW-1:0] a);
        return a + ADDR_ONE;
    endfunction

endpackage

// File: rtl/useq_cond_mux.sv
module useq_cond_mux
    import useq_pkg::*;
(
    input  status_t stat,
    input  cond_e   sel,
    output logic    hit
);
    logic [(1<<CW)-1:0] taps;

    always_comb begin
        taps                    = '0;
        taps[int'(COND_ALWAYS)] = 1'b1;
        taps[int'(COND_IND)]    = stat.indirect;
        taps[int'(COND_SIGN)]   = stat.sign;
        taps[int'(COND_ZERO)]   = stat.zero;
        hit                     = taps[sel];
    end
endmodule

// File: rtl/useq_next_sel.sv
module useq_next_sel
    import useq_pkg::*;
(
    input  logic [AW-1:0]  cur,
    input  cond_e          cd,
    input  br_e            br,
    input  logic [AW-1:0]  ad,
    input  logic           hit,
    input  logic [OPW-1:0] op,
    input  logic [AW-1:0]  saved,
    output logic [AW-1:0]  nxt,
    output src_e           src,
    output logic           save_en,
    output logic [AW-1:0]  save_val
);
    logic [AW-1:0] inc_addr;
    logic          unused_cd;

    assign inc_addr  = addr_inc(cur);
    assign unused_cd = ^cd;

    always_comb begin
        unique case (br)
            BR_JUMP, BR_CALL: src = hit ? SRC_FIELD : SRC_INC;
            BR_RETURN:        src = SRC_SAVED;
            default:          src = SRC_MAP;
        endcase
    end

    always_comb begin
        unique case (src)
            SRC_INC:   nxt = inc_addr;
            SRC_FIELD: nxt = ad;
            SRC_MAP:   nxt = map_opcode(op);
            default:   nxt = saved;
        endcase
    end

    assign save_en  = (br == BR_CALL) && hit;
    assign save_val = inc_addr;

    // R7: a mapped address always falls in the lower half of control memory
    always_comb begin
        if (src == SRC_MAP) begin
            assert_map_low_half_R7: assert (nxt[AW-1] == 1'b0);
        end
    end
endmodule

// File: rtl/useq_ret_reg.sv
module useq_ret_reg
    import useq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          save_en,
    input  logic [AW-1:0] d,
    output logic [AW-1:0] q
);
    logic rst_d;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst) begin
            q <= FETCH_ADDR;
        end else if (save_en) begin
            q <= d;
        end
    end

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !save_en |=> $stable(q));

    always @(posedge clk) begin
        if (rst_d && !rst) begin
            assert_reset_saved_R10: assert (q == FETCH_ADDR);
        end
    end
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
    import useq_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic [useq_pkg::UW-1:0]       uword,
    input  logic                          ind_bit,
    input  logic                          ac_sign,
    input  logic                          ac_zero,
    input  logic [useq_pkg::OPW-1:0]      opcode,
    output logic [useq_pkg::AW-1:0]       car
);
    uword_t        u;
    status_t       stat;
    logic          hit;
    logic [AW-1:0] nxt;
    src_e          src;
    logic          save_en;
    logic [AW-1:0] save_val;
    logic [AW-1:0] saved;
    logic          unused_ops;
    logic          rst_d;

    assign u          = uword_t'(uword);
    assign stat       = '{indirect: ind_bit, sign: ac_sign, zero: ac_zero};
    assign unused_ops = ^u.ops;

    useq_cond_mux u_cond (
        .stat (stat),
        .sel  (u.cd),
        .hit  (hit)
    );

    useq_next_sel u_sel (
        .cur      (car),
        .cd       (u.cd),
        .br       (u.br),
        .ad       (u.ad),
        .hit      (hit),
        .op       (opcode),
        .saved    (saved),
        .nxt      (nxt),
        .src      (src),
        .save_en  (save_en),
        .save_val (save_val)
    );

    useq_ret_reg u_ret (
        .clk     (clk),
        .rst     (rst),
        .save_en (save_en),
        .d       (save_val),
        .q       (saved)
    );

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst) begin
            car <= FETCH_ADDR;
        end else begin
            car <= nxt;
        end
    end

    always @(posedge clk) begin
        if (rst_d && !rst) begin
            assert_reset_fetch_R1: assert (car == FETCH_ADDR);
        end
    end

    assert_taken_R3: assert property (@(posedge clk) disable iff (rst)
        ((u.br == BR_JUMP || u.br == BR_CALL) && hit) |=> car == $past(u.ad));

    assert_fall_R4: assert property (@(posedge clk) disable iff (rst)
        ((u.br == BR_JUMP || u.br == BR_CALL) && !hit) |=> car == $past(car) + ADDR_ONE);

    assert_call_save_R5: assert property (@(posedge clk) disable iff (rst)
        (u.br == BR_CALL && hit) |=> saved == $past(car) + ADDR_ONE);

    assert_return_R6: assert property (@(posedge clk) disable iff (rst)
        (u.br == BR_RETURN) |=> car == $past(saved));

    assert_map_R7: assert property (@(posedge clk) disable iff (rst)
        (u.br == BR_MAP) |=> car == map_opcode($past(opcode)));

    assert_always_true_R2: assert property (@(posedge clk) disable iff (rst)
        (u.cd == COND_ALWAYS && u.br == BR_JUMP) |=> car == $past(u.ad));
endmodule

// File: tb/tb_useq_sequencer.sv
`timescale 1ns/1ps
module tb_useq_sequencer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] uword = '0;
    logic        ind_bit = 1'b0, ac_sign = 1'b0, ac_zero = 1'b0;
    logic [3:0]  opcode = '0;
    logic [6:0]  car;

    int checks = 0;
    int errors = 0;
    int m_car = 64;
    int m_sbr = 64;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    useq_sequencer dut (
        .clk(clk), .rst(rst), .uword(uword), .ind_bit(ind_bit),
        .ac_sign(ac_sign), .ac_zero(ac_zero), .opcode(opcode), .car(car)
    );

    function automatic logic [19:0] mk(input int ops, input int cd, input int br, input int ad);
        return {9'(ops), 2'(cd), 2'(br), 7'(ad)};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: car=%0d expected %0d", req, act, exp);
        end
    endtask

    // one clock: drive at negedge, model the edge, compare after it
    task automatic cyc(input logic [19:0] w, input logic i, input logic s, input logic z,
                       input logic [3:0] op, input logic r, input string req);
        int cd, br, ad;
        bit c;
        @(negedge clk);
        uword = w; ind_bit = i; ac_sign = s; ac_zero = z; opcode = op; rst = r;
        @(posedge clk);
        #1;
        cd = int'(w[10:9]); br = int'(w[8:7]); ad = int'(w[6:0]);
        case (cd)
            0: c = 1'b1;
            1: c = i;
            2: c = s;
            default: c = z;
        endcase
        if (r) begin
            m_car = 64; m_sbr = 64;
        end else begin
            case (br)
                0: m_car = c ? ad : (m_car + 1) % 128;
                1: if (c) begin m_sbr = (m_car + 1) % 128; m_car = ad; end
                   else m_car = (m_car + 1) % 128;
                2: m_car = m_sbr;
                default: m_car = int'(op) * 4;
            endcase
        end
        check(req, int'(car), m_car);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: car=%0d expected end of run", car);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        string tag;
        cyc(mk(0,0,0,5), 0,0,0, 4'd0, 1'b1, "R1");
        cyc(mk(0,0,0,5), 0,0,0, 4'd0, 1'b1, "R1");
        // fetch-like flow: always-true jump, then map
        cyc(mk(9'o600,0,0,65), 0,0,0, 4'd2, 1'b0, "R2 R3");
        cyc(mk(0,0,3,0), 1,1,1, 4'd2, 1'b0, "R7");           // opcode 2 -> 8
        cyc(mk(0,1,1,67), 1,0,0, 4'd3, 1'b0, "R5 R3");       // call taken, saves 9
        cyc(mk(0,3,2,0), 0,0,1, 4'd3, 1'b0, "R6");           // return -> 9
        cyc(mk(0,1,1,67), 0,0,0, 4'd3, 1'b0, "R4");          // call not taken -> 10
        cyc(mk(0,2,2,0), 0,1,0, 4'd3, 1'b0, "R8");           // return still -> 9
        cyc(mk(0,2,0,40), 0,1,0, 4'd0, 1'b0, "R2");          // sign true -> 40
        cyc(mk(0,3,0,90), 0,1,0, 4'd0, 1'b0, "R2");          // zero false -> 41
        cyc(mk(0,3,0,90), 0,0,1, 4'd0, 1'b0, "R2");          // zero true -> 90
        cyc(mk(0,2,0,12), 0,0,0, 4'd0, 1'b0, "R2 R4");       // sign false -> 91
        cyc(mk(0,0,0,127), 0,0,0, 4'd0, 1'b0, "R3");
        cyc(mk(0,1,0,5), 0,0,0, 4'd0, 1'b0, "R4");           // wrap 127 -> 0
        cyc(mk(0,0,0,127), 0,0,0, 4'd0, 1'b0, "R3");
        cyc(mk(0,0,1,50), 0,0,0, 4'd0, 1'b0, "R5");          // call at 127 saves 0
        cyc(mk(0,0,2,3), 0,0,0, 4'd0, 1'b0, "R5 R6");        // return -> 0
        cyc(mk(9'h1FF,1,0,33), 0,0,0, 4'd0, 1'b0, "R9");     // ops all ones, fall -> 1
        cyc(mk(9'h1FF,0,3,0), 0,0,0, 4'd15, 1'b0, "R7 R9");  // -> 60
        cyc(mk(9'h1FF,0,2,0), 0,0,0, 4'd15, 1'b0, "R8 R9");  // -> 0
        cyc(mk(0,0,1,20), 0,0,0, 4'd0, 1'b1, "R10");         // reset wins over call
        cyc(mk(0,0,2,0), 0,0,0, 4'd0, 1'b0, "R10");          // return -> 64
        for (int k = 0; k < 4000; k++) begin
            logic [19:0] w;
            w = 20'($urandom);
            case (w[8:7])
                2'b00: tag = "R2 R3 R4 R9";
                2'b01: tag = "R3 R4 R5 R9";
                2'b10: tag = "R6 R8 R9";
                default: tag = "R7 R8 R9";
            endcase
            cyc(w, 1'($urandom), 1'($urandom), 1'($urandom), 4'($urandom),
                ($urandom % 97) == 0, tag);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule